// File: doc/BRIEF.md
# Machine check bank read responder

This block answers sideband reads of a set of error-reporting banks. A request names a processor ID (one hardware thread), a bank number and one of four registers inside that bank. One cycle later the block returns 64 bits of data and a one-byte completion code. Banks 0 to 3 are private to each core. Two thread IDs map onto one core, so both threads of a core see the same contents. Banks 4 to 19 and a group of three global registers are shared, and they read the same for every ID.

The block guards its answers. A read of a private bank that belongs to a disabled or nonexistent core gives zero data with code 0x90. A reserved or undefined bank also gives zero data with code 0x90. A read of a bank that belongs to the inter-processor link, while that link is absent, gives zero data with code 0x40.

The error sources that fill the banks are modelled by one write port. The write port uses the same addressing as the read side. Only one request is handled at a time.

Top module: `mca_bank_reader`

## Requirements
- R1: After reset, resp_valid, resp_data and resp_cc are all zero. resp_valid is high in exactly the cycle after a cycle with req_valid high, and low otherwise. Every response carries code 0x40 (success) or 0x90 (invalid).
- R2: Banks 0 to 3 are per core. The core index is req_pid shifted right by one. IDs 2c and 2c+1 return the same word of core c, with code 0x40, and each core holds its own contents.
- R3: Banks 4, 5, 7, 9, 10, 11, 12, 17, 18 and 19 are shared. Each returns the same word with code 0x40 for every req_pid from 0 to 15.
- R4: Bank 31 holds the global registers: register select 0 is status, 1 is containment and 2 is capability. These return the same value for every req_pid, with code 0x40. Register select 3 of bank 31 returns zero data with code 0x90.
- R5: A read of banks 0 to 3 returns zero data with code 0x90 in two cases: core_en bit (req_pid>>1) is 0, or req_pid is 8 or higher.
- R6: While link_present is 0, banks 5 and 7 return zero data with code 0x40. No other bank changes.
- R7: Banks 6, 8, 13, 14, 15, 16 and 20 to 30 return zero data with code 0x90, including after writes were aimed at them.
- R8: A cycle with wr_en high stores wr_data at the location named by wr_pid, wr_bank and wr_reg, using the same mapping as a read. Later reads return the new value. Writes to reserved banks, undefined banks and bank 31 register 3 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all storage |
| req_valid | input | 1 | Read request strobe |
| req_pid | input | 4 | Processor (thread) ID of the request |
| req_bank | input | 5 | Bank number; 31 selects the global registers |
| req_reg | input | 2 | Register select: 0 control, 1 status, 2 address, 3 misc |
| core_en | input | 4 | Per-core enable, bit c for core c |
| link_present | input | 1 | Inter-processor link is enabled and present |
| wr_en | input | 1 | Error-source write strobe |
| wr_pid | input | 4 | Processor ID of the write |
| wr_bank | input | 5 | Bank number of the write |
| wr_reg | input | 2 | Register select of the write |
| wr_data | input | 64 | Value to store |
| resp_valid | output | 1 | Response valid, one cycle after the request |
| resp_data | output | 64 | Register contents, or zero |
| resp_cc | output | 8 | Completion code: 0x40 success, 0x90 invalid |

## Verification
The hardest case to reach from the ports is the one that shows a guard hides live data rather than reading an empty location. A reserved bank, a disabled core or an absent link reads as zero even when matching contents were written. To show this, the bench first fills every location, reserved and undefined ones included, with a distinct value computed from core, bank and register. It then sweeps every ID, bank and register under three settings of core enables and link presence. It also reads back each private bank through both thread IDs of its core, after writing it through only one of them.

// File: rtl/mca_bank_reader.sv
module mca_bank_reader #(
  parameter int N_CORES = 4,
  parameter int TID_W   = 1,
  parameter int PID_W   = 4,
  parameter int BANK_W  = 5,
  parameter int NPC     = 4,
  parameter int NBANK   = 20,
  parameter int DW      = 64,
  parameter int GLB_BANK = 31,
  parameter logic [(1<<BANK_W)-1:0] RSVD_MASK = 'h1E140,
  parameter logic [(1<<BANK_W)-1:0] LINK_MASK = 'h000A0,
  parameter logic [7:0] CC_OK  = 8'h40,
  parameter logic [7:0] CC_BAD = 8'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [1:0]        req_reg,
  input  logic [N_CORES-1:0] core_en,
  input  logic              link_present,
  input  logic              wr_en,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [1:0]        wr_reg,
  input  logic [DW-1:0]     wr_data,
  output logic              resp_valid,
  output logic [DW-1:0]     resp_data,
  output logic [7:0]        resp_cc
);
  localparam int CL_W     = $clog2(N_CORES);
  localparam int PB_W     = $clog2(NPC);
  localparam int UB_W     = $clog2(NBANK - NPC);
  localparam int PC_WORDS = N_CORES * NPC * 4;
  localparam int UC_WORDS = (NBANK - NPC) * 4;
  localparam int PC_AW    = CL_W + PB_W + 2;
  localparam int UC_AW    = UB_W + 2;

  typedef enum logic [1:0] {K_CORE, K_UNC, K_GLB, K_BAD} kind_t;

  function automatic kind_t classify(input logic [BANK_W-1:0] b, input logic [1:0] r);
    if (b == BANK_W'(GLB_BANK)) return (r == 2'd3) ? K_BAD : K_GLB;
    if (b >= BANK_W'(NBANK))    return K_BAD;
    if (RSVD_MASK[b])           return K_BAD;
    if (b < BANK_W'(NPC))       return K_CORE;
    return K_UNC;
  endfunction

  logic [DW-1:0] pc_mem [PC_WORDS];
  logic [DW-1:0] uc_mem [UC_WORDS];
  logic [DW-1:0] g_stat, g_cont, g_cap;

  // read side address decode
  kind_t             rk;
  logic [PID_W-1:0]  r_core;
  logic              r_core_ok;
  logic [BANK_W-1:0] r_ub;
  logic [PC_AW-1:0]  r_pa;
  logic [UC_AW-1:0]  r_ua;
  logic [DW-1:0]     d_nx;
  logic [7:0]        cc_nx;

  assign rk        = classify(req_bank, req_reg);
  assign r_core    = req_pid >> TID_W;
  assign r_core_ok = (r_core < PID_W'(N_CORES)) && core_en[r_core[CL_W-1:0]];
  assign r_ub      = req_bank - BANK_W'(NPC);
  assign r_pa      = {r_core[CL_W-1:0], req_bank[PB_W-1:0], req_reg};
  assign r_ua      = {r_ub[UB_W-1:0], req_reg};

  always_comb begin
    d_nx  = '0;
    cc_nx = CC_BAD;
    case (rk)
      K_CORE: if (r_core_ok) begin
        d_nx  = pc_mem[r_pa];
        cc_nx = CC_OK;
      end
      K_UNC: begin
        cc_nx = CC_OK;
        if (!(LINK_MASK[req_bank] && !link_present)) d_nx = uc_mem[r_ua];
      end
      K_GLB: begin
        cc_nx = CC_OK;
        case (req_reg)
          2'd0:    d_nx = g_stat;
          2'd1:    d_nx = g_cont;
          default: d_nx = g_cap;
        endcase
      end
      default: ;
    endcase
  end

  // write side address decode
  kind_t             wk;
  logic [PID_W-1:0]  w_core;
  logic [BANK_W-1:0] w_ub;
  logic [PC_AW-1:0]  w_pa;
  logic [UC_AW-1:0]  w_ua;

  assign wk     = classify(wr_bank, wr_reg);
  assign w_core = wr_pid >> TID_W;
  assign w_ub   = wr_bank - BANK_W'(NPC);
  assign w_pa   = {w_core[CL_W-1:0], wr_bank[PB_W-1:0], wr_reg};
  assign w_ua   = {w_ub[UB_W-1:0], wr_reg};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PC_WORDS; i++) pc_mem[i] <= '0;
      for (int i = 0; i < UC_WORDS; i++) uc_mem[i] <= '0;
      g_stat <= '0;
      g_cont <= '0;
      g_cap  <= '0;
    end else if (wr_en) begin
      case (wk)
        K_CORE: if (w_core < PID_W'(N_CORES)) pc_mem[w_pa] <= wr_data;
        K_UNC:  uc_mem[w_ua] <= wr_data;
        K_GLB:
          case (wr_reg)
            2'd0:    g_stat <= wr_data;
            2'd1:    g_cont <= wr_data;
            default: g_cap  <= wr_data;
          endcase
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
      resp_cc    <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_data <= d_nx;
        resp_cc   <= cc_nx;
      end
    end
  end
endmodule

// File: rtl/mca_bank_reader_chk.sv
module mca_bank_reader_chk #(
  parameter int TID_W = 1,
  parameter int PID_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [PID_W-1:0] req_pid,
  input logic [4:0]       req_bank,
  input logic [3:0]       core_en,
  input logic             link_present,
  input logic             resp_valid,
  input logic [63:0]      resp_data,
  input logic [7:0]       resp_cc
);
  logic [PID_W-1:0] core;
  logic core_dead, rsvd, link_bank;
  assign core      = req_pid >> TID_W;
  assign core_dead = (core >= PID_W'(4)) || !core_en[core[1:0]];
  assign rsvd      = (req_bank == 5'd6) || (req_bank == 5'd8) ||
                     ((req_bank >= 5'd13) && (req_bank <= 5'd16)) ||
                     ((req_bank >= 5'd20) && (req_bank <= 5'd30));
  assign link_bank = (req_bank == 5'd5) || (req_bank == 5'd7);

  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> resp_valid); // R1
  AST_NO_SPURIOUS:  assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !resp_valid); // R1
  AST_CC_LEGAL:     assert property (@(posedge clk) disable iff (!rst_n) resp_valid |-> (resp_cc == 8'h40 || resp_cc == 8'h90)); // R1
  AST_DEAD_CORE:    assert property (@(posedge clk) disable iff (!rst_n)
                      (req_valid && req_bank < 5'd4 && core_dead) |=> (resp_cc == 8'h90 && resp_data == '0)); // R5
  AST_LINK_OFF:     assert property (@(posedge clk) disable iff (!rst_n)
                      (req_valid && link_bank && !link_present) |=> (resp_cc == 8'h40 && resp_data == '0)); // R6
  AST_RESERVED:     assert property (@(posedge clk) disable iff (!rst_n)
                      (req_valid && rsvd) |=> (resp_cc == 8'h90 && resp_data == '0)); // R7
endmodule

bind mca_bank_reader mca_bank_reader_chk u_chk (.*);

// File: tb/sim_mca_bank_reader.sv
`timescale 1ns/1ps
module sim_mca_bank_reader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, link_present = 1, wr_en = 0;
  logic [3:0] req_pid = 0, wr_pid = 0, core_en = 4'hF;
  logic [4:0] req_bank = 0, wr_bank = 0;
  logic [1:0] req_reg = 0, wr_reg = 0;
  logic [63:0] wr_data = 0;
  logic resp_valid;
  logic [63:0] resp_data;
  logic [7:0] resp_cc;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mca_bank_reader u0 (.*);

  function automatic logic [63:0] pat(int c, int b, int r);
    return {16'hC0DE, 8'(c), 8'(b), 8'(r), 8'h5A, 16'(c*1000 + b*10 + r)};
  endfunction

  function automatic bit is_rsvd(int b);
    return b == 6 || b == 8 || (b >= 13 && b <= 16) || (b >= 20 && b <= 30);
  endfunction

  task automatic chk(string tag, logic [63:0] ad, logic [7:0] ac, logic [63:0] ed, logic [7:0] ec);
    total++;
    if (ad !== ed || ac !== ec) begin
      bad++;
      $display("FAIL %s: data=%h cc=%h expected data=%h cc=%h", tag, ad, ac, ed, ec);
    end
  endtask

  task automatic wr(int pid, int b, int r, logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_pid = 4'(pid); wr_bank = 5'(b); wr_reg = 2'(r); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int pid, int b, int r, output logic [63:0] d, output logic [7:0] cc, output logic v);
    @(negedge clk);
    req_valid = 1; req_pid = 4'(pid); req_bank = 5'(b); req_reg = 2'(r);
    @(negedge clk);
    req_valid = 0;
    d = resp_data; cc = resp_cc; v = resp_valid;
  endtask

  task automatic expect_of(int pid, int b, int r, output logic [63:0] ed, output logic [7:0] ec, output string tag);
    int c;
    ed = '0; ec = 8'h90;
    if (b == 31) begin
      tag = "R4";
      if (r < 3) begin ed = pat(14, 31, r); ec = 8'h40; end
    end else if (is_rsvd(b)) begin
      tag = "R7";
    end else if (b < 4) begin
      c = pid >> 1;
      if (c < 4 && core_en[c]) begin tag = "R2"; ed = pat(c, b, r); ec = 8'h40; end
      else tag = "R5";
    end else begin
      ec = 8'h40;
      if (!link_present && (b == 5 || b == 7)) tag = "R6";
      else begin tag = "R3"; ed = pat(15, b, r); end
    end
  endtask

  task automatic sweep();
    logic [63:0] d, ed; logic [7:0] cc, ec; logic v; string tag;
    for (int p = 0; p < 16; p++)
      for (int b = 0; b < 32; b++)
        for (int r = 0; r < 4; r++) begin
          rd(p, b, r, d, cc, v);
          expect_of(p, b, r, ed, ec, tag);
          if (!v) chk("R1", {63'd0, v}, 8'h0, 64'd1, 8'h0);
          chk(tag, d, cc, ed, ec);
        end
  endtask

  initial begin
    logic [63:0] d; logic [7:0] cc; logic v;
    repeat (3) @(negedge clk);
    chk("R1", {63'd0, resp_valid}, resp_cc, 64'd0, 8'h00);
    chk("R1", resp_data, 8'h0, 64'd0, 8'h0);
    rst_n = 1;
    @(negedge clk);
    rd(3, 2, 1, d, cc, v);
    chk("R1", d, cc, 64'd0, 8'h40);
    @(negedge clk);
    chk("R1", {63'd0, resp_valid}, 8'h0, 64'd0, 8'h0);
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 4; r++) wr(2*c + (c & 1), b, r, pat(c, b, r));
    for (int b = 4; b < 31; b++)
      for (int r = 0; r < 4; r++) wr(b & 15, b, r, is_rsvd(b) ? pat(9, b, r) : pat(15, b, r));
    for (int r = 0; r < 4; r++) wr(r * 5, 31, r, r < 3 ? pat(14, 31, r) : pat(9, 31, r));
    wr(9, 0, 0, pat(9, 0, 0));
    core_en = 4'hF; link_present = 1; sweep();
    core_en = 4'b0101; link_present = 0; sweep();
    core_en = 4'b1010; link_present = 1; sweep();
    wr(7, 3, 2, 64'h0123_4567_89AB_CDEF);
    rd(6, 3, 2, d, cc, v);
    chk("R8", d, cc, 64'h0123_4567_89AB_CDEF, 8'h40);
    wr(1, 12, 3, 64'hFEED_0000_0000_0001);
    rd(14, 12, 3, d, cc, v);
    chk("R8", d, cc, 64'hFEED_0000_0000_0001, 8'h40);
    rd(0, 5, 0, d, cc, v);
    chk("R8", d, cc, pat(15, 5, 0), 8'h40);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1: watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule